// File: doc/BRIEF.md
# Retro Bitmap Video Scan-out

This block produces the raster timing and serial pixel stream for a small monochrome bitmap display with a fixed 64 x 128 pixel picture. The timing is counted in byte slots rather than individual pixels. Each line has a fixed number of byte slots, and only some of them show picture. A frame has a fixed number of lines, and only the first block of lines is active. For every active byte, the block fetches one byte from the read port of a dual-port frame buffer. A separate writer fills that buffer at its own rate, so the picture timing never depends on how fast the writer runs.

The fetch for a byte is issued one byte slot before that byte is displayed. The byte is then shifted out most significant bit first, so bit 7 is the leftmost pixel of its group of eight. The block also drives horizontal and vertical sync, a blanking flag and a one-bit pixel that feeds a composite video DAC. It exports its line and byte-slot counters so that neighbouring logic can align to the raster.

Top module: `bitmap_scanout`

## Requirements
- R1: While reset is asserted, `line_cnt` and `byte_cnt` are 0, `hsync` and `vsync` are low, `blank` is high and `pix` is 0.
- R2: Each byte slot lasts 8 clocks. `byte_cnt` counts 0..13 and wraps to 0. `line_cnt` advances when `byte_cnt` wraps and counts 0..261 before wrapping to 0.
- R3: `rd_en` is high exactly on the first clock of byte slots 0..7 on lines 0..127, with `rd_addr` = line*8 + slot. It is low on every other clock. The frame buffer returns data one clock after `rd_en`.
- R4: During clock k (0..7) of byte slot s (1..8) on active line l, `pix` equals bit 7-k of the buffer byte at address l*8 + s - 1. The most significant bit is the leftmost pixel.
- R5: `blank` is low exactly during byte slots 1..8 of lines 0..127. Whenever `blank` is high, `pix` is 0.
- R6: `hsync` is high exactly during byte slots 10 and 11 of every line.
- R7: `vsync` is high exactly during lines 200..203 of every frame.
- R8: The buffer contents are sampled only at fetch time. Bytes rewritten during inactive lines appear in the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | output | 1 | Frame buffer read strobe |
| rd_addr | output | 10 | Frame buffer read address |
| rd_data | input | 8 | Frame buffer read data, valid one clock after `rd_en` |
| pix | output | 1 | Serial pixel, 1 = white |
| blank | output | 1 | High outside the active picture |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| line_cnt | output | 9 | Current scan line |
| byte_cnt | output | 4 | Current byte slot within the line |

## Verification
The sync, blank, counter and read-strobe outputs all decode the raster counters combinationally. They are therefore due in the same clock in which the counters reach a slot. The bench derives the expected slot and line from the number of clock edges since reset, and it compares all outputs on the falling edge of every clock. A pixel is due one byte slot after its fetch: the read is issued on clock 0 of slot s, the data is loaded on clock 7, and the pixel appears on clock 0 of slot s+1. The bench models that as a plain lookup of byte l*8+s-1 in its own memory array. Buffer rewrites happen only during inactive lines, so each rewrite is checked in the next frame.

// File: rtl/bitmap_scanout.sv
module bitmap_scanout #(
  parameter int PPB      = 8,
  parameter int BPL      = 14,
  parameter int ABYTES   = 8,
  parameter int LINES    = 262,
  parameter int ALINES   = 128,
  parameter int HS_START = 10,
  parameter int HS_LEN   = 2,
  parameter int VS_START = 200,
  parameter int VS_LEN   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        rd_en,
  output logic [9:0]  rd_addr,
  input  logic [7:0]  rd_data,
  output logic        pix,
  output logic        blank,
  output logic        hsync,
  output logic        vsync,
  output logic [8:0]  line_cnt,
  output logic [3:0]  byte_cnt
);
  localparam int PW = $clog2(PPB);
  localparam int BW = $clog2(BPL);
  localparam int LW = $clog2(LINES);
  localparam int AW = $clog2(ALINES * ABYTES);

  logic [PW-1:0]  pc;
  logic [BW-1:0]  bc;
  logic [LW-1:0]  lc;
  logic [PPB-1:0] sh;

  wire last_px   = pc == PW'(PPB - 1);
  wire last_byte = bc == BW'(BPL - 1);
  wire last_line = lc == LW'(LINES - 1);
  wire act_line  = lc < LW'(ALINES);
  wire fetch     = act_line && bc < BW'(ABYTES);
  wire disp      = act_line && bc != '0 && bc <= BW'(ABYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      bc <= '0;
      lc <= '0;
    end else begin
      pc <= last_px ? '0 : pc + 1'b1;
      if (last_px) begin
        bc <= last_byte ? '0 : bc + 1'b1;
        if (last_byte) lc <= last_line ? '0 : lc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              sh <= '0;
    else if (fetch && last_px) sh <= rd_data;
    else                     sh <= {sh[PPB-2:0], 1'b0};
  end

  assign rd_en    = fetch && pc == '0;
  assign rd_addr  = AW'(lc) * AW'(ABYTES) + AW'(bc);
  assign pix      = disp && sh[PPB-1];
  assign blank    = !disp;
  assign hsync    = bc >= BW'(HS_START) && bc < BW'(HS_START + HS_LEN);
  assign vsync    = lc >= LW'(VS_START) && lc < LW'(VS_START + VS_LEN);
  assign line_cnt = lc;
  assign byte_cnt = bc;
endmodule

// File: rtl/scanout_props.sv
module scanout_props #(
  parameter int PPB    = 8,
  parameter int BPL    = 14,
  parameter int ABYTES = 8,
  parameter int LINES  = 262,
  parameter int ALINES = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pc,
  input logic [3:0] byte_cnt,
  input logic [8:0] line_cnt,
  input logic       rd_en,
  input logic       blank,
  input logic       pix,
  input logic       hsync,
  input logic       vsync
);
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt < 4'(BPL) && line_cnt < 9'(LINES));

  assert_byte_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt == 4'(BPL - 1) && pc == 3'(PPB - 1)) |=> byte_cnt == 4'd0);

  assert_read_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (pc == 3'd0 && byte_cnt < 4'(ABYTES) && line_cnt < 9'(ALINES)));

  assert_blank_black_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !pix);

  assert_hsync_blanked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> blank);

  assert_vsync_blanked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> blank);
endmodule

bind bitmap_scanout scanout_props #(
  .PPB(PPB), .BPL(BPL), .ABYTES(ABYTES), .LINES(LINES), .ALINES(ALINES)
) u_props (
  .clk(clk), .rst_n(rst_n), .pc(pc), .byte_cnt(byte_cnt), .line_cnt(line_cnt),
  .rd_en(rd_en), .blank(blank), .pix(pix), .hsync(hsync), .vsync(vsync)
);

// File: tb/sim_bitmap_scanout.sv
`timescale 1ns/1ps
module sim_bitmap_scanout;
  localparam int FRAME = 262 * 14 * 8;
  localparam int RUN   = 2 * FRAME + 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en, pix, blank, hsync, vsync;
  logic [9:0] rd_addr;
  logic [7:0] rd_data;
  logic [8:0] line_cnt;
  logic [3:0] byte_cnt;
  logic [7:0] mem [1024];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  bitmap_scanout u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pix(pix), .blank(blank), .hsync(hsync), .vsync(vsync),
    .line_cnt(line_cnt), .byte_cnt(byte_cnt)
  );

  function automatic int f_pc(int n); return n % 8; endfunction
  function automatic int f_bc(int n); return (n / 8) % 14; endfunction
  function automatic int f_lc(int n); return (n / 112) % 262; endfunction
  function automatic bit f_act(int n);
    return f_lc(n) < 128 && f_bc(n) >= 1 && f_bc(n) <= 8;
  endfunction
  function automatic bit f_pix(int n);
    logic [7:0] b;
    if (!f_act(n)) return 1'b0;
    b = mem[f_lc(n) * 8 + f_bc(n) - 1];
    return b[7 - f_pc(n)];
  endfunction

  task automatic chk(string req, int act, int exp, int n);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, n, act, exp);
    end
  endtask

  task automatic check_all(int n);
    bit ren;
    ren = f_lc(n) < 128 && f_bc(n) < 8 && f_pc(n) == 0;
    chk("R2 byte_cnt", byte_cnt, f_bc(n), n);
    chk("R2 line_cnt", line_cnt, f_lc(n), n);
    chk("R3 rd_en", rd_en, ren, n);
    if (ren) chk("R3 rd_addr", rd_addr, f_lc(n) * 8 + f_bc(n), n);
    chk("R5 blank", blank, !f_act(n), n);
    chk("R4 R8 pix", pix, f_pix(n), n);
    chk("R6 hsync", hsync, f_bc(n) == 10 || f_bc(n) == 11, n);
    chk("R7 vsync", vsync, f_lc(n) >= 200 && f_lc(n) <= 203, n);
  endtask

  initial begin
    void'($urandom(1861));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    mem[0] = 8'h80; mem[7] = 8'h01; mem[1016] = 8'hFF; mem[1023] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 line_cnt", line_cnt, 0, -1);
    chk("R1 byte_cnt", byte_cnt, 0, -1);
    chk("R1 hsync", hsync, 0, -1);
    chk("R1 vsync", vsync, 0, -1);
    chk("R1 blank", blank, 1, -1);
    chk("R1 pix", pix, 0, -1);
    rst_n = 1'b1;
    check_all(0);
    for (int n = 1; n < RUN; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_all(n);
      if (n == 130 * 112) begin
        for (int i = 0; i < 64; i++) mem[$urandom % 1024] = 8'($urandom);
        mem[0] = 8'h01; mem[7] = 8'h80; mem[1016] = 8'h00; mem[1023] = 8'hFF;
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * (RUN + 2000));
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule